// File: doc/BRIEF.md
# Fractional Baud Rate Tick Generator

This block turns a fast reference clock into the two timing strobes a UART needs: a sampling strobe at sixteen times the bit rate, and a bit strobe at the bit rate itself. Software sets the rate through three small registers on a simple write port. Two of them hold the low and high bytes of a 16-bit integer divisor. The third holds a 4-bit fraction in sixteenths.

The sampling period is N reference cycles, where N is the integer divisor. To reach a divisor of N + F/16, F of every sixteen periods are lengthened to N + 1 cycles. A 4-bit phase accumulator picks those periods, so they are spread as evenly as the fraction allows. The resulting bit rate is fclk / (16 × (N + F/16)). For example, with a 24 MHz reference, N = 1 and F = 10 give about 921.6 kbaud with an error near 0.16 %, N = 1 and F = 8 give exactly 1 Mbaud, and N = 13 with F = 0 gives 115.2 kbaud.

A divisor change takes effect at the next period boundary, so a period already in progress is never cut short. An integer part of zero stops both strobes.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, all three divisor registers read as zero, and neither tick16_o nor tick1_o pulses until a non-zero integer divisor is written.
- R2: A write with wr_en high stores wr_data according to wr_sel: code 0 loads the low divisor byte, code 1 loads the high divisor byte, and code 2 loads the fraction from wr_data[3:0]. A write with code 3 changes nothing.
- R3: With fraction 0 and integer divisor N ≥ 2, tick16_o is a single-cycle pulse repeating exactly every N cycles.
- R4: With integer divisor N and fraction F, every tick16_o interval is N or N+1 cycles, and any 16 consecutive intervals sum to 16·N + F cycles.
- R5: Any 8 consecutive tick16_o intervals contain either floor(F/2) or ceil(F/2) lengthened intervals.
- R6: tick1_o pulses only together with tick16_o, on every sixteenth tick16_o pulse, so successive tick1_o pulses are 16·N + F cycles apart.
- R7: When the integer divisor is zero at a period boundary, the strobes stop from the next cycle on. Writing a non-zero integer divisor restarts them.
- R8: A divisor write does not alter the period in progress. The new value governs the periods that start after the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 fraction, 3 unused |
| wr_data | input | 8 | Write data |
| tick16_o | output | 1 | Sampling strobe at 16× the bit rate |
| tick1_o | output | 1 | Bit-rate strobe |

## Verification
The checker enforces several rules on every cycle:
- a bit strobe always lands on a sampling strobe, and two bit strobes never come in consecutive cycles;
- a sampling strobe cannot repeat in the next cycle when the divisor is two or more;
- the strobe stops right after a boundary that sees a zero divisor;
- an unused select code leaves the divisor untouched.

Other behaviour spans long windows, and only the bench scenarios can show it. This covers the exact sixteen-period sum for each fraction, the even spread of the lengthened periods, the spacing of the bit strobe, and the fact that a write mid-period lets the old period finish.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_INT_W  = 16;
    localparam int DIV_FRAC_W = 4;
    localparam int BYTE_W     = 8;
    localparam int SEL_W      = 2;
    localparam int OVERSAMPLE = 16;
    localparam int CNT_W      = DIV_INT_W + 1;
    localparam int SUB_W      = $clog2(OVERSAMPLE);

    typedef struct packed {
        logic [DIV_INT_W-1:0]  whole;
        logic [DIV_FRAC_W-1:0] frac;
    } div_regs_t;

    typedef struct packed {
        logic                  run;
        logic [CNT_W-1:0]      cnt;
        logic [DIV_FRAC_W-1:0] phase;
    } period_state_t;
endpackage

// File: rtl/baud_divreg.sv
module baud_divreg
    import baud_pkg::*;
#(
    parameter int INT_W  = DIV_INT_W,
    parameter int FRAC_W = DIV_FRAC_W,
    parameter int BW     = BYTE_W,
    parameter int SW     = SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [BW-1:0]     wr_data,
    output logic [INT_W-1:0]  div_int_o,
    output logic [FRAC_W-1:0] div_frac_o
);
    localparam int NBYTES = INT_W / BW;

    logic [INT_W-1:0]  int_d, int_q;
    logic [FRAC_W-1:0] frac_d, frac_q;
    logic [NBYTES-1:0] hit;

    // one select decoder per divisor byte
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte_hit
        assign hit[b] = wr_en && (wr_sel == SW'(b));
    end

    always_comb begin
        int_d  = int_q;
        frac_d = frac_q;
        for (int b = 0; b < NBYTES; b++) begin
            if (hit[b]) int_d[b*BW +: BW] = wr_data;
        end
        if (wr_en && (wr_sel == SW'(NBYTES))) frac_d = wr_data[FRAC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            frac_q <= '0;
        end else begin
            int_q  <= int_d;
            frac_q <= frac_d;
        end
    end

    assign div_int_o  = int_q;
    assign div_frac_o = frac_q;
endmodule

// File: rtl/baud_period.sv
module baud_period
    import baud_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_INT_W-1:0]  div_int_i,
    input  logic [DIV_FRAC_W-1:0] div_frac_i,
    output logic                  tick_o
);
    period_state_t         st_d, st_q;
    logic [DIV_FRAC_W:0]   phase_sum;
    logic                  stretch;
    logic [CNT_W-1:0]      next_len;
    logic                  tick;

    always_comb begin
        st_d      = st_q;
        phase_sum = {1'b0, st_q.phase} + {1'b0, div_frac_i};
        stretch   = phase_sum[DIV_FRAC_W];
        next_len  = CNT_W'(div_int_i) + CNT_W'(stretch);
        tick      = st_q.run && (st_q.cnt == CNT_W'(1));

        if (!st_q.run) begin
            if (div_int_i != '0) begin
                st_d.run   = 1'b1;
                st_d.cnt   = next_len;
                st_d.phase = phase_sum[DIV_FRAC_W-1:0];
            end
        end else if (tick) begin
            if (div_int_i == '0) begin
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt   = next_len;
                st_d.phase = phase_sum[DIV_FRAC_W-1:0];
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick;
endmodule

// File: rtl/baud_subdiv.sv
module baud_subdiv
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick16_i,
    output logic tick1_o
);
    logic [SUB_W-1:0] sub_d, sub_q;

    always_comb begin
        sub_d = sub_q;
        if (tick16_i) sub_d = sub_q + SUB_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end

    assign tick1_o = tick16_i && (sub_q == SUB_W'(OVERSAMPLE - 1));
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic             tick16_o,
    output logic             tick1_o
);
    logic [DIV_INT_W-1:0]  div_int;
    logic [DIV_FRAC_W-1:0] div_frac;

    baud_divreg u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .div_int_o  (div_int),
        .div_frac_o (div_frac)
    );

    baud_period u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_int_i  (div_int),
        .div_frac_i (div_frac),
        .tick_o     (tick16_o)
    );

    baud_subdiv u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16_i (tick16_o),
        .tick1_o  (tick1_o)
    );
endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk
    import baud_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [SEL_W-1:0]      wr_sel,
    input logic [DIV_INT_W-1:0]  div_int,
    input logic [DIV_FRAC_W-1:0] div_frac,
    input logic                  tick16,
    input logic                  tick1
);
    a_r6_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |-> tick16);

    a_r6_bit_not_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |=> !tick1);

    a_r7_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && div_int == '0) |=> !tick16);

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && div_int >= DIV_INT_W'(2)) |=> !tick16);

    a_r2_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(3)) |=> $stable({div_int, div_frac}));
endmodule

bind baud_frac_gen baud_frac_gen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .div_int  (div_int),
    .div_frac (div_frac),
    .tick16   (tick16_o),
    .tick1    (tick1_o)
);

// File: tb/baud_frac_gen_tb_top.sv
module baud_frac_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       tick16_o, tick1_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    baud_frac_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tick16_o (tick16_o),
        .tick1_o  (tick1_o)
    );

    // hi[39:32] lo[31:24] frac[23:16] expected 16-period sum [15:0]
    localparam int NV = 7;
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 8'h01, 8'h0A, 16'd26},
        {8'h00, 8'h0D, 8'h00, 16'd208},
        {8'h00, 8'h01, 8'h08, 16'd24},
        {8'h00, 8'h03, 8'h00, 16'd48},
        {8'h00, 8'h06, 8'h00, 16'd96},
        {8'h00, 8'h02, 8'h0F, 16'd47},
        {8'h01, 8'h00, 8'h03, 16'd4099}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // cycles from current negedge until tick16_o is seen high at a negedge
    task automatic wait16(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick16_o && n < 20000);
    endtask

    task automatic wait1(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick1_o && n < 20000);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, sum, longc, nint, fr, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, no strobes
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (tick16_o || tick1_o) seen++;
        end
        check(seen == 0, "R1 idle after reset", seen, 0);

        // table-driven rate checks (R4, R5, R6, R2)
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VEC[v][31:24]);
            wr(2'd1, VEC[v][39:32]);
            wr(2'd2, VEC[v][23:16]);
            nint = {VEC[v][39:32], VEC[v][31:24]};
            fr   = int'(VEC[v][19:16]);
            wait16(n);
            wait16(n);
            sum = 0;
            longc = 0;
            seen = 0;
            for (int k = 0; k < 16; k++) begin
                wait16(n);
                sum += n;
                if (n != nint && n != nint + 1) seen++;
                if (k < 8 && n == nint + 1) longc++;
            end
            check(seen == 0, "R4 interval range", seen, 0);
            check(sum == int'(VEC[v][15:0]), "R4 16-period sum", sum, int'(VEC[v][15:0]));
            check(longc == fr / 2 || longc == (fr + 1) / 2, "R5 spread of stretched periods",
                  longc, fr / 2);
            wait1(n);
            wait1(n);
            check(n == int'(VEC[v][15:0]), "R6 bit strobe spacing", n, int'(VEC[v][15:0]));
        end

        // R3 + R2: integer rate, unused select code ignored
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h05);
        wait16(n);
        wait16(n);
        wr(2'd3, 8'h77);
        wait16(n);
        wait16(n);
        check(n == 5, "R2 code 3 ignored", n, 5);
        wait16(n);
        check(n == 5, "R3 integer period", n, 5);
        @(negedge clk);
        check(!tick16_o, "R3 single-cycle pulse", int'(tick16_o), 0);

        // R8: write at a boundary keeps the old period once
        wr(2'd0, 8'd40);
        wait16(n);
        wait16(n);
        wait16(n);
        wr(2'd0, 8'd4);
        wait16(n);
        check(n + 1 == 40, "R8 old period completes", n + 1, 40);
        wait16(n);
        check(n == 4, "R8 new period applies", n, 4);

        // R8: write mid-period
        repeat (2) @(negedge clk);
        wr(2'd0, 8'd9);
        wait16(n);
        check(n + 3 == 4, "R8 mid-period write deferred", n + 3, 4);
        wait16(n);
        check(n == 9, "R8 mid-period new value", n, 9);

        // R7: zero divisor halts
        wr(2'd0, 8'd0);
        repeat (12) @(negedge clk);
        seen = 0;
        repeat (200) begin
            @(negedge clk);
            if (tick16_o || tick1_o) seen++;
        end
        check(seen == 0, "R7 zero divisor halts", seen, 0);
        wr(2'd0, 8'd3);
        wait16(n);
        wait16(n);
        check(n == 3, "R7 restart after zero", n, 3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule